// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block computes the quotient or the remainder of two 64-bit integers over many clock cycles. A three-bit operation code picks one of eight variants: word (32-bit) or doubleword (64-bit) width, signed or unsigned interpretation, and quotient or remainder result. Word variants first widen the low 32 bits of each operand, by sign or by zero as the variant requires. The 64-bit result of every word variant is the sign extension of the low 32 bits.

The unit never traps. A zero divisor acts as a divisor of one, so the quotient equals the widened dividend and the remainder is zero. For signed doubleword division of the most negative value by minus one, the divisor is also treated as one. That gives the most negative value as the quotient and zero as the remainder.

Signed variants divide magnitudes with a restoring radix-2 loop and restore the signs afterwards. The quotient truncates toward zero and the remainder carries the sign of the dividend. A pulse on `start` while the unit is idle launches an operation. `busy` stays high while it runs, and `done` pulses for one cycle when the result is written.

Top module: `divRemUnit`

## Requirements
- R1: The operation code `op` has three bits. Bit 2 set means doubleword and clear means word, bit 1 set means unsigned, and bit 0 set selects the remainder instead of the quotient. The codes are 0 signed word quotient, 1 signed word remainder, 2 unsigned word quotient, 3 unsigned word remainder, 4 signed doubleword quotient, 5 signed doubleword remainder, 6 unsigned doubleword quotient and 7 unsigned doubleword remainder.
- R2: Signed word variants sign-extend bits [31:0] of both operands, divide them as signed values, and return the sign extension of bits [31:0] of the outcome.
- R3: Unsigned word variants zero-extend bits [31:0] of both operands, divide them as unsigned values, and return the sign extension of bits [31:0] of the outcome.
- R4: Signed doubleword variants return the quotient truncated toward zero, or a remainder that has the sign of the dividend.
- R5: Unsigned doubleword variants return the unsigned quotient or remainder of the full 64-bit operands.
- R6: When the widened divisor is zero, the quotient is the widened dividend and the remainder is zero. Word variants then apply the usual sign extension of bits [31:0].
- R7: Signed doubleword division of 0x8000000000000000 by all-ones yields a quotient of 0x8000000000000000 and a remainder of 0.
- R8: Counting the clock edge that accepts `start` as edge zero, `done` is high after edge 33 for word variants and after edge 65 for doubleword variants. `busy` is high from edge zero until that edge.
- R9: `done` is high for exactly one cycle, and `busy` is low in that cycle. `result` changes only in a cycle in which `done` is high, and it holds its value until the next completion.
- R10: A `start` while `busy` is high is ignored. The running operation keeps its operands, its result and its latency.
- R11: After reset, `busy`, `done` and `result` are all zero.
- R12: A `start` given in the same cycle that `done` is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, taken only when not busy |
| op | input | 3 | Operation code (width, signedness, result select) |
| dividend | input | 64 | Dividend operand |
| divisor | input | 64 | Divisor operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotient or remainder of the latest completed operation |

## Verification
The completion pulse of one operation and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `start` with fresh operands in the cycle in which it first sees `done`. It then judges both operations: the first result must be intact in the `done` cycle, and the second operation must return its own expected value with the normal latency. A second collision, a `start` during a running operation, is provoked part way through a doubleword division. It is judged by checking that the original result and the latency of 65 are unchanged.

// File: rtl/divRemPkg.sv
package divRemPkg;
  localparam int OP_W = 3;
  localparam int OP_REM_BIT = 0;
  localparam int OP_UNS_BIT = 1;
  localparam int OP_DBL_BIT = 2;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIX  = 2'd2
  } divStateT;

  typedef struct packed {
    logic load;
    logic step;
    logic fix;
  } divCtrlT;
endpackage

// File: rtl/divRemDatapath.sv
module divRemDatapath
  import divRemPkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  divCtrlT         ctrl,
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic [XLEN-1:0] result
);
  localparam int HALF = XLEN - WLEN;
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

  function automatic logic [XLEN-1:0] widen(input logic [WLEN-1:0] v, input logic sgn);
    return sgn ? {{HALF{v[WLEN-1]}}, v} : {{HALF{1'b0}}, v};
  endfunction

  logic isWordIn, isUnsIn, minCase, aNeg, bNeg;
  logic [XLEN-1:0] aExt, bExt, bEff, aMag, bMag;
  logic [XLEN-1:0] remReg, quoReg, dvsrReg;
  logic negQ, negR, remSel, wordSel;
  logic [XLEN:0] shifted, diff;
  logic [XLEN-1:0] qFix, rFix, pick, fixed;

  // operand conditioning at launch
  always_comb begin
    isWordIn = !op[OP_DBL_BIT];
    isUnsIn  = op[OP_UNS_BIT];
    aExt = isWordIn ? widen(dividend[WLEN-1:0], !isUnsIn) : dividend;
    bExt = isWordIn ? widen(divisor[WLEN-1:0], !isUnsIn) : divisor;
    minCase = !isUnsIn && !isWordIn && (aExt == MOST_NEG) && (bExt == '1);
    bEff = ((bExt == '0) || minCase) ? XLEN'(1) : bExt;
    aNeg = !isUnsIn && aExt[XLEN-1];
    bNeg = !isUnsIn && bEff[XLEN-1];
    aMag = aNeg ? -aExt : aExt;
    bMag = bNeg ? -bEff : bEff;
  end

  // one restoring step and the final sign repair
  always_comb begin
    shifted = {remReg, quoReg[XLEN-1]};
    diff    = shifted - {1'b0, dvsrReg};
    qFix    = negQ ? -quoReg : quoReg;
    rFix    = negR ? -remReg : remReg;
    pick    = remSel ? rFix : qFix;
    fixed   = wordSel ? widen(pick[WLEN-1:0], 1'b1) : pick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg  <= '0;
      quoReg  <= '0;
      dvsrReg <= '0;
      negQ    <= 1'b0;
      negR    <= 1'b0;
      remSel  <= 1'b0;
      wordSel <= 1'b0;
      result  <= '0;
    end else begin
      if (ctrl.load) begin
        remReg  <= '0;
        quoReg  <= isWordIn ? (aMag << HALF) : aMag;
        dvsrReg <= bMag;
        negQ    <= aNeg ^ bNeg;
        negR    <= aNeg;
        remSel  <= op[OP_REM_BIT];
        wordSel <= isWordIn;
      end
      if (ctrl.step) begin
        remReg <= diff[XLEN] ? shifted[XLEN-1:0] : diff[XLEN-1:0];
        quoReg <= {quoReg[XLEN-2:0], ~diff[XLEN]};
      end
      if (ctrl.fix) result <= fixed;
    end
  end
endmodule

// File: rtl/divRemControl.sv
module divRemControl
  import divRemPkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    opDouble,
  output divCtrlT ctrl,
  output logic    busy,
  output logic    done
);
  localparam int CNTW = $clog2(XLEN + 1);

  divStateT state;
  logic [CNTW-1:0] stepsLeft;

  always_comb begin
    ctrl.load = (state == S_IDLE) && start;
    ctrl.step = (state == S_RUN);
    ctrl.fix  = (state == S_FIX);
    busy      = (state != S_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      stepsLeft <= '0;
      done      <= 1'b0;
    end else begin
      done <= (state == S_FIX);
      case (state)
        S_IDLE: if (start) begin
          state     <= S_RUN;
          stepsLeft <= opDouble ? CNTW'(XLEN) : CNTW'(WLEN);
        end
        S_RUN: begin
          stepsLeft <= stepsLeft - 1'b1;
          if (stepsLeft == CNTW'(1)) state <= S_FIX;
        end
        S_FIX:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divRemUnit.sv
module divRemUnit
  import divRemPkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  divCtrlT ctrl;

  divRemControl #(.XLEN(XLEN), .WLEN(WLEN)) uControl (
    .clk(clk), .rstN(rstN), .start(start), .opDouble(op[OP_DBL_BIT]),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  divRemDatapath #(.XLEN(XLEN), .WLEN(WLEN)) uDatapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .op(op),
    .dividend(dividend), .divisor(divisor), .result(result)
  );
endmodule

// File: rtl/divRemUnit_chk.sv
module divRemUnit_chk #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [2:0]      op,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] result
);
  localparam int CW = $clog2(XLEN + 2) + 1;
  logic wordOp;
  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOp <= 1'b0;
      since  <= '0;
    end else if (start && !busy) begin
      wordOp <= !op[2];
      since  <= '0;
    end else if (busy) begin
      since <= since + 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result)); // R9
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R12
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !$past(done)) |=> (busy || done)); // R10
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (since == (wordOp ? CW'(WLEN + 1) : CW'(XLEN + 1)))); // R8
  AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rstN)
    (done && wordOp) |-> (result[XLEN-1:WLEN-1] == '0 || result[XLEN-1:WLEN-1] == '1)); // R2
endmodule

bind divRemUnit divRemUnit_chk #(.XLEN(XLEN), .WLEN(WLEN)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .op(op),
  .busy(busy), .done(done), .result(result)
);

// File: tb/divRemUnit_test.sv
`timescale 1ns/1ps
module divRemUnit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [63:0] dividend = '0, divisor = '0;
  logic busy, done;
  logic [63:0] result;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  divRemUnit uut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .result(result)
  );

  // Reference from the requirements; R1 gives the code meaning.
  function automatic logic [63:0] refModel(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b);
    logic w, u;
    logic [63:0] x, y, q, r, res;
    w = !o[2];
    u = o[1];
    x = w ? (u ? {32'h0, a[31:0]} : {{32{a[31]}}, a[31:0]}) : a;
    y = w ? (u ? {32'h0, b[31:0]} : {{32{b[31]}}, b[31:0]}) : b;
    if (y == 64'd0) begin
      q = x; r = 64'd0;                                   // R6
    end else if (!u && !w && x == 64'h8000_0000_0000_0000 && y == '1) begin
      q = x; r = 64'd0;                                   // R7
    end else if (u) begin
      q = x / y; r = x % y;
    end else begin
      q = $signed(x) / $signed(y); r = $signed(x) % $signed(y);
    end
    res = o[0] ? r : q;
    if (w) res = {{32{res[31]}}, res[31:0]};
    return res;
  endfunction

  function automatic string tagFor(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b);
    logic w;
    w = !o[2];
    if ((w && b[31:0] == 32'd0) || (!w && b == 64'd0)) return "R6";
    if (o[2:1] == 2'b10 && a == 64'h8000_0000_0000_0000 && b == '1) return "R7";
    if (w) return o[1] ? "R3" : "R2";
    return o[1] ? "R5" : "R4";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; drives start across one rising edge
  task automatic launch(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b);
    op = o; dividend = a; divisor = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(inout int lat);
    int guard = 0;
    while (!done && guard < 300) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic runOne(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b);
    int lat = 0;
    launch(o, a, b);
    waitDone(lat);
    check(tagFor(o, a, b), result, refModel(o, a, b));
    check("R8", 64'(lat), o[2] ? 64'd65 : 64'd33);
  endtask

  logic [63:0] vals [12];

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vals[0] = 64'd0;                     vals[1] = 64'd1;
    vals[2] = 64'd2;                     vals[3] = '1;
    vals[4] = 64'd7;                     vals[5] = -64'd7;
    vals[6] = 64'h8000_0000_0000_0000;   vals[7] = 64'h7FFF_FFFF_FFFF_FFFF;
    vals[8] = 64'h0000_0000_8000_0000;   vals[9] = 64'hFFFF_FFFF_8000_0000;
    vals[10] = 64'h0000_0000_FFFF_FFFF;  vals[11] = 64'h1234_5678_9ABC_DEF0;

    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {62'd0, busy, done}, 64'd0);
    check("R11", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // sweep of all eight codes over the corner operand set (R1..R8)
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          runOne(3'(o), vals[i], vals[j]);

    // R9: done is one cycle, busy low with it, result held afterwards
    begin
      logic [63:0] held;
      int lat = 0;
      launch(3'd5, -64'd100, 64'd7);
      waitDone(lat);
      check("R9", {63'd0, busy}, 64'd0);
      held = result;
      @(negedge clk);
      check("R9", {63'd0, done}, 64'd0);
      dividend = 64'd999; divisor = 64'd3;
      repeat (4) @(negedge clk);
      check("R9", result, held);
      check("R4", held, 64'hFFFF_FFFF_FFFF_FFFE);
    end

    // R10: a start during a running doubleword divide is ignored
    begin
      int lat = 0;
      launch(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd10);
      repeat (5) begin
        @(posedge clk); lat++; @(negedge clk);
      end
      op = 3'd1; dividend = 64'd5; divisor = 64'd2; start = 1'b1;
      @(posedge clk); lat++; @(negedge clk);
      start = 1'b0;
      waitDone(lat);
      check("R10", result, 64'h1999_9999_9999_9999);
      check("R10", 64'(lat), 64'd65);
      @(negedge clk);
      check("R10", {63'd0, busy}, 64'd0);
    end

    // R12: new start in the done cycle
    begin
      int lat = 0;
      launch(3'd0, 64'd100, -64'd3);
      waitDone(lat);
      check("R2", result, -64'd33);
      lat = 0;
      launch(3'd3, 64'h0000_0000_FFFF_FFFF, 64'd16);
      waitDone(lat);
      check("R12", result, 64'd15);
      check("R12", 64'(lat), 64'd33);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule